// File: doc/BRIEF.md
# Mode-Banked Register Index Mapper

This block keeps the processor status word and a set of saved-status copies. It also turns architectural integer register numbers into physical register-file indices. The low five bits of the status word select the processor mode. That mode decides two things: which physical entry a banked register name reaches, and which saved-status copy the saved-status port sees. The register file itself sits outside this block. A decode stage drives the translation port and feeds the result combinationally into the file's address, so a translation costs no cycle.

There are sixteen architectural registers. The physical file holds 33 entries:
- the sixteen shared entries;
- five fast-interrupt copies of r8 to r12;
- one stack/link pair (r13/r14) for each of the six exception modes.

Indices at or above the architectural count address the physical file directly. Indices at or above the physical count wrap back onto the shared set. The block also exports the reset image of the system control word.

Top module: `bank_remap`

## Requirements
- R1: After reset the status word reads 0x0000_0010 (user mode), every saved-status copy reads zero, the error flag is low and translation follows the user-mode mapping.
- R2: The system control output reads 0x0800_0078: bit 27 (non-maskable fast interrupt) and the reserved read-as-one bits 6 to 3 are set, and every other bit is clear.
- R3: A status write whose bits 4:0 hold a recognized mode is stored whole at the clock edge, and the mapping follows the new mode from the next cycle. The recognized modes are user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, monitor 0x16, abort 0x17, undefined 0x1B and system 0x1F.
- R4: A status write with any other mode value leaves the status word and the mapping unchanged. It raises the error flag for exactly the following cycle. In every other cycle the flag is low.
- R5: Indices 0 to 7 and index 15 translate to themselves in every mode.
- R6: Indices 8 to 12 translate to 16 to 20 in fast-interrupt mode and to themselves in all other modes.
- R7: Indices 13 and 14 translate to the pair 13/14 in user and system modes. The other modes use these pairs: fast interrupt 21/22, interrupt 23/24, supervisor 25/26, abort 27/28, undefined 29/30, monitor 31/32.
- R8: Indices 16 to 32 pass through unchanged in every mode, with the range error low.
- R9: An index from 33 to 48 translates to the index minus 33 without banking, with the range error low. Indices 49 to 63 raise the range error.
- R10: A saved-status write lands in the copy of the mode current in that cycle, taken before any status write in the same cycle. The read port combinationally returns the current mode's copy.
- R11: Fast interrupt, interrupt, supervisor, monitor, abort and undefined each own a separate copy. User and system share one generic copy, so a write made in one of those modes is visible in the other and in no other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sts_we | input | 1 | Status word write enable |
| sts_wdata | input | 32 | Status word write value |
| sts_q | output | 32 | Current status word |
| sts_err | output | 1 | Rejected mode write, one cycle |
| ss_we | input | 1 | Saved-status write enable |
| ss_wdata | input | 32 | Saved-status write value |
| ss_rdata | output | 32 | Saved-status copy of the current mode |
| xl_idx | input | 6 | Register number to translate |
| xl_phys | output | 6 | Physical register-file index |
| xl_err | output | 1 | Register number beyond the wrap range |
| sysctl_q | output | 32 | System control reset image |

## Verification
The saved-status property assumes that no status write happens in the same cycle. A same-cycle status write changes the mode, and so the copy, that the next read sees. That pairing is left to the reference model, and the stimulus drives it on purpose in a separate phase. The translation properties assume only that the index is a stable six-bit value between edges. The stimulus sweeps all 64 index values in every recognized mode. It places rejected mode values between valid ones, so the hold-over of the previous mapping can be seen at the ports.

// File: rtl/bank_remap_pkg.sv
package bank_remap_pkg;

  localparam logic [4:0] MD_USR = 5'h10;
  localparam logic [4:0] MD_FIQ = 5'h11;
  localparam logic [4:0] MD_IRQ = 5'h12;
  localparam logic [4:0] MD_SVC = 5'h13;
  localparam logic [4:0] MD_MON = 5'h16;
  localparam logic [4:0] MD_ABT = 5'h17;
  localparam logic [4:0] MD_UND = 5'h1B;
  localparam logic [4:0] MD_SYS = 5'h1F;

  localparam logic [31:0] CTL_INIT = 32'h0800_0078;

  // bank order fixes the r13/r14 pair placement in the physical file
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5,
    BK_MON = 3'd6
  } bank_e;

  localparam int NBANK = 7;

  typedef struct packed {
    logic  known;
    bank_e bank;
  } mode_dec_t;

  function automatic mode_dec_t mode_decode(input logic [4:0] m);
    mode_dec_t d;
    d.known = 1'b1;
    case (m)
      MD_USR, MD_SYS: d.bank = BK_USR;
      MD_FIQ:         d.bank = BK_FIQ;
      MD_IRQ:         d.bank = BK_IRQ;
      MD_SVC:         d.bank = BK_SVC;
      MD_MON:         d.bank = BK_MON;
      MD_ABT:         d.bank = BK_ABT;
      MD_UND:         d.bank = BK_UND;
      default: begin
        d.known = 1'b0;
        d.bank  = BK_USR;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bank_idx_xlate.sv
module bank_idx_xlate
  import bank_remap_pkg::*;
#(
  parameter int ARCH_REGS = 16,
  parameter int FIQ_LO    = 8,
  parameter int FIQ_CNT   = 5,
  parameter int SP_REG    = 13,
  parameter int PHYS_REGS = 33,
  parameter int IDX_W     = 6,
  parameter int PIDX_W    = 6
) (
  input  bank_e             bank,
  input  logic [IDX_W-1:0]  idx,
  output logic [PIDX_W-1:0] phys,
  output logic              err
);

  localparam int AW = $clog2(ARCH_REGS);

  function automatic int map_entry(input int b, input int r);
    if (b == int'(BK_FIQ) && r >= FIQ_LO && r < FIQ_LO + FIQ_CNT)
      return ARCH_REGS + r - FIQ_LO;
    if (b != int'(BK_USR) && (r == SP_REG || r == SP_REG + 1))
      return ARCH_REGS + FIQ_CNT + 2 * (b - 1) + (r - SP_REG);
    return r;
  endfunction

  logic [PIDX_W-1:0] tbl [NBANK][ARCH_REGS];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar r = 0; r < ARCH_REGS; r++) begin : g_reg
      assign tbl[b][r] = PIDX_W'(map_entry(b, r));
    end
  end

  logic [IDX_W-1:0] wrap;

  always_comb begin
    wrap = idx - IDX_W'(PHYS_REGS);
    err  = 1'b0;
    if (idx < IDX_W'(ARCH_REGS)) begin
      phys = tbl[int'(bank)][idx[AW-1:0]];
    end else if (idx < IDX_W'(PHYS_REGS)) begin
      phys = PIDX_W'(idx);
    end else begin
      phys = PIDX_W'(wrap);
      err  = (wrap >= IDX_W'(ARCH_REGS));
    end
  end

endmodule

// File: rtl/bank_ss_store.sv
module bank_ss_store
  import bank_remap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  bank_e           sel,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);

  logic [XLEN-1:0] slot_q [NBANK];
  logic [NBANK-1:0] slot_en;

  for (genvar s = 0; s < NBANK; s++) begin : g_slot
    assign slot_en[s] = we && (int'(sel) == s);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[s] <= '0;
      else if (slot_en[s]) slot_q[s] <= wdata;
    end
  end

  assign rdata = slot_q[int'(sel)];

endmodule

// File: rtl/bank_remap.sv
module bank_remap
  import bank_remap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int ARCH_REGS = 16,
  parameter int FIQ_LO    = 8,
  parameter int FIQ_CNT   = 5,
  parameter int SP_REG    = 13,
  localparam int PHYS_REGS = ARCH_REGS + FIQ_CNT + 2 * (NBANK - 1),
  localparam int IDX_W     = $clog2(PHYS_REGS + ARCH_REGS),
  localparam int PIDX_W    = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sts_we,
  input  logic [XLEN-1:0]   sts_wdata,
  output logic [XLEN-1:0]   sts_q,
  output logic              sts_err,
  input  logic              ss_we,
  input  logic [XLEN-1:0]   ss_wdata,
  output logic [XLEN-1:0]   ss_rdata,
  input  logic [IDX_W-1:0]  xl_idx,
  output logic [PIDX_W-1:0] xl_phys,
  output logic              xl_err,
  output logic [XLEN-1:0]   sysctl_q
);

  logic rst_sync_n;

  bank_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [XLEN-1:0] sts_d;
  bank_e           bank_q, bank_d;
  logic            err_d, err_q;
  mode_dec_t       wdec;

  // the bank is chosen from the incoming mode field before the word is kept
  always_comb begin
    wdec   = mode_decode(sts_wdata[4:0]);
    sts_d  = sts_q;
    bank_d = bank_q;
    err_d  = 1'b0;
    if (sts_we) begin
      if (wdec.known) begin
        sts_d  = sts_wdata;
        bank_d = wdec.bank;
      end else begin
        err_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sts_q  <= XLEN'(MD_USR);
      bank_q <= BK_USR;
      err_q  <= 1'b0;
    end else begin
      sts_q  <= sts_d;
      bank_q <= bank_d;
      err_q  <= err_d;
    end
  end

  assign sts_err  = err_q;
  assign sysctl_q = XLEN'(CTL_INIT);

  bank_ss_store #(.XLEN(XLEN)) u_ss (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .sel   (bank_q),
    .we    (ss_we),
    .wdata (ss_wdata),
    .rdata (ss_rdata)
  );

  bank_idx_xlate #(
    .ARCH_REGS (ARCH_REGS),
    .FIQ_LO    (FIQ_LO),
    .FIQ_CNT   (FIQ_CNT),
    .SP_REG    (SP_REG),
    .PHYS_REGS (PHYS_REGS),
    .IDX_W     (IDX_W),
    .PIDX_W    (PIDX_W)
  ) u_xl (
    .bank (bank_q),
    .idx  (xl_idx),
    .phys (xl_phys),
    .err  (xl_err)
  );

endmodule

// File: rtl/bank_remap_chk.sv
module bank_remap_chk
  import bank_remap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 33,
  parameter int IDX_W     = 6,
  parameter int PIDX_W    = 6
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              sts_we,
  input logic [XLEN-1:0]   sts_wdata,
  input logic [XLEN-1:0]   sts_q,
  input logic              sts_err,
  input logic              ss_we,
  input logic [XLEN-1:0]   ss_wdata,
  input logic [XLEN-1:0]   ss_rdata,
  input logic [IDX_W-1:0]  xl_idx,
  input logic [PIDX_W-1:0] xl_phys,
  input logic              xl_err
);

  logic wr_ok, wr_bad;
  assign wr_ok  = sts_we && mode_decode(sts_wdata[4:0]).known;
  assign wr_bad = sts_we && !mode_decode(sts_wdata[4:0]).known;

  assert_sts_store_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_ok |=> sts_q == $past(sts_wdata));

  assert_bad_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_bad |=> (sts_err && sts_q == $past(sts_q)));

  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_bad |=> !sts_err);

  assert_ss_readback_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ss_we && !sts_we) |=> ss_rdata == $past(ss_wdata));

  assert_low_ident_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xl_idx < IDX_W'(8)) |-> (xl_phys == PIDX_W'(xl_idx) && !xl_err));

  assert_mid_pass_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xl_idx >= IDX_W'(ARCH_REGS) && xl_idx < IDX_W'(PHYS_REGS))
      |-> (xl_phys == PIDX_W'(xl_idx) && !xl_err));

  assert_range_err_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xl_err |-> (xl_idx >= IDX_W'(PHYS_REGS + ARCH_REGS)));

endmodule

bind bank_remap bank_remap_chk #(
  .XLEN      (XLEN),
  .ARCH_REGS (ARCH_REGS),
  .PHYS_REGS (PHYS_REGS),
  .IDX_W     (IDX_W),
  .PIDX_W    (PIDX_W)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .sts_we     (sts_we),
  .sts_wdata  (sts_wdata),
  .sts_q      (sts_q),
  .sts_err    (sts_err),
  .ss_we      (ss_we),
  .ss_wdata   (ss_wdata),
  .ss_rdata   (ss_rdata),
  .xl_idx     (xl_idx),
  .xl_phys    (xl_phys),
  .xl_err     (xl_err)
);

// File: tb/bank_remap_tb_top.sv
module bank_remap_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sts_we = 1'b0;
  logic [31:0] sts_wdata = '0;
  logic [31:0] sts_q;
  logic        sts_err;
  logic        ss_we = 1'b0;
  logic [31:0] ss_wdata = '0;
  logic [31:0] ss_rdata;
  logic [5:0]  xl_idx = '0;
  logic [5:0]  xl_phys;
  logic        xl_err;
  logic [31:0] sysctl_q;

  bank_remap dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sts_we    (sts_we),
    .sts_wdata (sts_wdata),
    .sts_q     (sts_q),
    .sts_err   (sts_err),
    .ss_we     (ss_we),
    .ss_wdata  (ss_wdata),
    .ss_rdata  (ss_rdata),
    .xl_idx    (xl_idx),
    .xl_phys   (xl_phys),
    .xl_err    (xl_err),
    .sysctl_q  (sysctl_q)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  // reference model state
  int m_sts;
  int m_err;
  int m_saved [7];

  function automatic bit known(input int m);
    return m == 'h10 || m == 'h11 || m == 'h12 || m == 'h13 ||
           m == 'h16 || m == 'h17 || m == 'h1B || m == 'h1F;
  endfunction

  function automatic int slot_of(input int m);
    case (m)
      'h11: return 1;
      'h12: return 2;
      'h13: return 3;
      'h16: return 4;
      'h17: return 5;
      'h1B: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_phys(input int m, input int i);
    if (i >= 33) return i - 33;
    if (i >= 16) return i;
    if (i >= 8 && i <= 12 && m == 'h11) return 16 + i - 8;
    if (i == 13 || i == 14) begin
      case (m)
        'h11: return 21 + i - 13;
        'h12: return 23 + i - 13;
        'h13: return 25 + i - 13;
        'h17: return 27 + i - 13;
        'h1B: return 29 + i - 13;
        'h16: return 31 + i - 13;
        default: return i;
      endcase
    end
    return i;
  endfunction

  function automatic string xl_tag(input int i);
    if (i < 8 || i == 15) return "R5";
    if (i <= 12) return "R6";
    if (i <= 14) return "R7";
    if (i <= 32) return "R8";
    return "R9";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string sts_tag, input string ss_tag);
    int ep;
    bit ee;
    ep = exp_phys(m_sts & 'h1F, int'(xl_idx));
    ee = int'(xl_idx) >= 49;
    chk(sts_q == 32'(m_sts), sts_tag, "status", sts_q, m_sts);
    chk(sts_err == m_err[0], "R4", "status error", sts_err, m_err);
    chk(ss_rdata == 32'(m_saved[slot_of(m_sts & 'h1F)]), ss_tag, "saved status",
        ss_rdata, m_saved[slot_of(m_sts & 'h1F)]);
    chk(xl_err == ee, xl_tag(int'(xl_idx)), "range error", xl_err, ee);
    if (!ee)
      chk(int'(xl_phys) == ep, xl_tag(int'(xl_idx)), "phys index", xl_phys, ep);
    chk(sysctl_q == 32'h0800_0078, "R2", "system control", sysctl_q, 32'h0800_0078);
  endtask

  // one clock: advance the model with the inputs held across the edge
  task automatic tick(input string sts_tag = "R3", input string ss_tag = "R10");
    int old_mode;
    @(posedge clk);
    old_mode = m_sts & 'h1F;
    if (ss_we) m_saved[slot_of(old_mode)] = int'(ss_wdata);
    m_err = 0;
    if (sts_we) begin
      if (known(int'(sts_wdata[4:0]))) m_sts = int'(sts_wdata);
      else m_err = 1;
    end
    @(negedge clk);
    compare(sts_tag, ss_tag);
  endtask

  task automatic set_status(input logic [31:0] v);
    sts_we = 1'b1;
    sts_wdata = v;
    tick("R3");
    sts_we = 1'b0;
  endtask

  task automatic write_saved(input logic [31:0] v);
    ss_we = 1'b1;
    ss_wdata = v;
    tick("R3", "R10");
    ss_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  int modes [8] = '{'h10, 'h11, 'h12, 'h13, 'h16, 'h17, 'h1B, 'h1F};

  initial begin
    m_sts = 'h10;
    m_err = 0;
    foreach (m_saved[k]) m_saved[k] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick("R1", "R1");

    // R1: reset mapping sweep in user mode
    for (int i = 0; i < 64; i++) begin
      xl_idx = 6'(i);
      tick("R1", "R1");
    end

    // R3/R5..R9: every recognized mode, full index sweep
    foreach (modes[k]) begin
      set_status(32'hA500_0000 | 32'(modes[k]));
      for (int i = 0; i < 64; i++) begin
        xl_idx = 6'(i);
        tick();
      end
    end

    // R10/R11: distinct value into each mode's copy, then read back in all
    foreach (modes[k]) begin
      set_status(32'(modes[k]));
      write_saved(32'h1234_0000 + 32'(k * 'h111));
    end
    foreach (modes[k]) begin
      set_status(32'(modes[k]));
      tick("R3", "R11");
    end

    // R4: rejected mode values keep the previous status and mapping
    set_status(32'h0000_0011);
    xl_idx = 6'd9;
    set_status(32'hFFFF_FFE0);
    tick("R4");
    set_status(32'h0000_0014);
    set_status(32'h0000_001A);
    tick("R4");
    xl_idx = 6'd13;
    set_status(32'h0000_0015);
    tick("R4");

    // R10: saved-status write in the same cycle as a mode change uses old mode
    set_status(32'h0000_0012);
    ss_we = 1'b1;
    ss_wdata = 32'hCAFE_0001;
    sts_we = 1'b1;
    sts_wdata = 32'h0000_0017;
    tick("R3", "R10");
    ss_we = 1'b0;
    sts_we = 1'b0;
    set_status(32'h0000_0012);
    tick("R3", "R10");

    // R11: system write visible in user mode
    set_status(32'h0000_001F);
    write_saved(32'h5A5A_A5A5);
    set_status(32'h0000_0010);
    tick("R3", "R11");

    // R1: reset again restores everything
    rst_n = 1'b0;
    m_sts = 'h10;
    m_err = 0;
    foreach (m_saved[k]) m_saved[k] = 0;
    @(negedge clk);
    rst_n = 1'b1;
    xl_idx = 6'd14;
    repeat (3) tick("R1", "R1");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule